// File: doc/BRIEF.md
# SPI Master Controller

A register-mapped SPI master that moves one word at a time. Software sets the link up through a mode register: clock phase, clock idle polarity, bit order, internal loopback, word length and a two-stage SCK prescaler. It then writes a word to the transmit register. The controller shifts the word out on `mosiOut` and samples `misoIn` on the opposite clock edges. When the word is complete, it places the received bits in the receive register at a fixed position that depends on bit order.

Two event flags report progress. One says the transmit register can accept a word. The other says a received word is waiting. Each flag is cleared by writing a one to it. A mask register selects which flags raise `irqOut`. A select register drives the chip-select lines directly, and a read-only capability word reports the longest word supported and the number of select lines.

The register port is one write strobe with an address, plus a read data bus that decodes the address combinationally. Register word addresses: 0 mode, 1 event, 2 mask, 3 transmit (reads as zero), 4 receive, 5 select, 6 capability.

Top module: `spi_m_top`

## Requirements
- R1: After reset, mode reads 0, event reads 0x1 (transmit-ready set, word-waiting clear), mask reads 0, `irqOut` is low and `sckOut` is low.
- R2: Mode layout: bit 0 enable, bit 1 CPHA, bit 2 CPOL, bit 3 MSB-first, bit 4 loopback, bits 11:8 length code, bit 12 extra divide-by-16, bits 19:16 prescale PM. While enable is set, a mode write changes only the enable bit and every other field keeps its value.
- R3: The length code holds word length minus one. Code 0 selects 32-bit words. Exactly that many bits are exchanged per word.
- R4: Each SCK half period lasts 2×(PM+1) clock cycles, which gives SCK = clk/(4×(PM+1)). With divide-by-16 set, it lasts 32×(PM+1) cycles.
- R5: Between words, SCK rests at the CPOL level. With CPHA 0, the first bit is on `mosiOut` before the first SCK edge and data is sampled on leading edges. With CPHA 1, data is driven on leading edges and sampled on trailing edges.
- R6: MSB-first words are sent from bit 31 downward. LSB-first words are sent from bit 0 upward.
- R7: For words of 16 bits or fewer, an MSB-first received word is returned with its LSB at bit 16, and an LSB-first received word with its MSB at bit 15. All other bits read zero. A 32-bit word is returned as received.
- R8: With loopback set, the sampled data is the controller's own `mosiOut`, and `misoIn` is ignored.
- R9: Event bit 0 (transmit ready) clears when the transmit register is written and sets when that word enters the shifter. Event bit 1 (word waiting) sets when a word completes. Writing a one to an event bit clears it.
- R10: `irqOut` is high exactly when some event bit and the mask bit at the same position are both set.
- R11: Clearing enable aborts the word in progress: SCK returns to its idle level and no word-waiting event follows. Transmit writes made while enable is clear are ignored.
- R12: The select register drives `selOut` and resets to all ones. The capability word reads 0x0004011F for four select lines: bits 4:0 hold 31, bit 8 says select lines exist, bits 23:16 hold their count. Writes to it are ignored.
- R13: The controller has one buffer. A completed word overwrites an unread receive word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` |
| irqOut | output | 1 | Masked event interrupt |
| sckOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data out |
| misoIn | input | 1 | Serial data in |
| selOut | output | NSEL | Chip-select lines |

## Verification
Words are exchanged with a bench slave across every CPHA/CPOL pairing, both bit orders and the lengths 4, 8, 12, 16 and 32. Each run compares the captured MOSI sequence and the justified receive word, so a wrong shift direction, wrong edge or wrong justification offset shows up as a distinct mismatch. The prescale settings are chosen to separate the plain divider from the divide-by-16 path. Loopback, the abort, back-to-back overwrite and the event/mask cases each exercise one control path in isolation.

// File: rtl/spi_m_pkg.sv
`timescale 1ns/1ps
package spi_m_pkg;
  parameter int DATA_W = 32;
  parameter int LEN_W  = 4;
  parameter int PM_W   = 4;
  parameter int ADDR_W = 3;
  localparam int HALF_W = PM_W + 6;
  localparam int WLEN_W = $clog2(DATA_W) + 1;
  localparam int EDGE_W = WLEN_W + 1;

  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_EVENT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TX    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RX    = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SEL   = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_CAP   = 3'd6;

  localparam int EV_NF = 0;
  localparam int EV_NE = 1;

  typedef struct packed {
    logic [PM_W-1:0]  pm;
    logic             div16;
    logic [LEN_W-1:0] lenF;
    logic             loopBack;
    logic             msbFirst;
    logic             cpol;
    logic             cpha;
    logic             en;
  } spiMode_t;

  typedef struct packed {
    logic load;
    logic drive;
    logic sample;
    logic done;
    logic abort;
  } spiStrobe_t;

  function automatic logic [DATA_W-1:0] modeToWord(spiMode_t m);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = m.en;
    w[1] = m.cpha;
    w[2] = m.cpol;
    w[3] = m.msbFirst;
    w[4] = m.loopBack;
    w[8 +: LEN_W] = m.lenF;
    w[12] = m.div16;
    w[16 +: PM_W] = m.pm;
    return w;
  endfunction

  function automatic spiMode_t wordToMode(logic [DATA_W-1:0] w);
    spiMode_t m;
    m.en       = w[0];
    m.cpha     = w[1];
    m.cpol     = w[2];
    m.msbFirst = w[3];
    m.loopBack = w[4];
    m.lenF     = w[8 +: LEN_W];
    m.div16    = w[12];
    m.pm       = w[16 +: PM_W];
    return m;
  endfunction
endpackage

// File: rtl/spi_m_datapath.sv
`timescale 1ns/1ps
module spi_m_datapath
  import spi_m_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  input  logic [DATA_W-1:0] txWord,
  input  logic              msbFirst,
  input  logic              loopBack,
  input  logic              fullWord,
  input  logic              misoIn,
  output logic              mosiOut,
  output logic [DATA_W-1:0] rxWord
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] shiftQ, rxShiftQ, rxAfter, rxJust, srcWord;
  logic inBit;

  function automatic logic headBit(logic [DATA_W-1:0] w, logic m);
    return m ? w[DATA_W-1] : w[0];
  endfunction

  function automatic logic [DATA_W-1:0] advance(logic [DATA_W-1:0] w, logic m);
    return m ? {w[DATA_W-2:0], 1'b0} : {1'b0, w[DATA_W-1:1]};
  endfunction

  assign inBit   = loopBack ? mosiOut : misoIn;
  assign srcWord = stb.load ? txWord : shiftQ;

  always_comb begin
    rxAfter = rxShiftQ;
    if (stb.sample)
      rxAfter = msbFirst ? {rxShiftQ[DATA_W-2:0], inBit} : {inBit, rxShiftQ[DATA_W-1:1]};
    if (fullWord)
      rxJust = rxAfter;
    else
      rxJust = msbFirst ? (rxAfter << HALF) : (rxAfter >> HALF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ   <= '0;
      rxShiftQ <= '0;
      mosiOut  <= 1'b0;
      rxWord   <= '0;
    end else if (stb.abort) begin
      shiftQ   <= '0;
      rxShiftQ <= '0;
    end else begin
      if (stb.drive) begin
        mosiOut <= headBit(srcWord, msbFirst);
        shiftQ  <= advance(srcWord, msbFirst);
      end else if (stb.load) begin
        shiftQ <= txWord;
      end
      if (stb.load)
        rxShiftQ <= '0;
      else if (stb.sample)
        rxShiftQ <= rxAfter;
      if (stb.done)
        rxWord <= rxJust;
    end
  end
endmodule

// File: rtl/spi_m_control.sv
`timescale 1ns/1ps
module spi_m_control
  import spi_m_pkg::*;
#(
  parameter int NSEL = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rxWord,
  output logic [DATA_W-1:0] regRdData,
  output spiStrobe_t        stb,
  output spiMode_t          modeCfg,
  output logic [DATA_W-1:0] txWord,
  output logic              fullWord,
  output logic              sckOut,
  output logic              irqOut,
  output logic [NSEL-1:0]   selOut
);
  localparam logic [DATA_W-1:0] CAP_WORD =
    {8'd0, 8'(NSEL), 7'd0, 1'b1, 3'd0, 5'(DATA_W - 1)};

  spiMode_t          modeQ;
  logic [1:0]        evtQ, evtN, maskQ;
  logic [NSEL-1:0]   selQ;
  logic [DATA_W-1:0] txQ;
  logic              txFullQ, busyQ, sckQ;
  logic [EDGE_W-1:0] edgeQ, lastIdx;
  logic [HALF_W-1:0] prescQ, halfLen, halfM1;
  logic [WLEN_W-1:0] wordLen;
  logic wrModeS, wrEvtS, wrMaskS, wrTxS, wrSelS;
  logic loadS, tickS, lastS, leadS, nfSet;

  assign wrModeS = regWrEn && regAddr == ADDR_MODE;
  assign wrEvtS  = regWrEn && regAddr == ADDR_EVENT;
  assign wrMaskS = regWrEn && regAddr == ADDR_MASK;
  assign wrSelS  = regWrEn && regAddr == ADDR_SEL;
  assign wrTxS   = regWrEn && regAddr == ADDR_TX && modeQ.en;

  assign wordLen = (modeQ.lenF == '0) ? WLEN_W'(DATA_W) : WLEN_W'(modeQ.lenF) + 1'b1;
  assign lastIdx = {wordLen, 1'b0} - 1'b1;
  assign halfLen = (HALF_W'(modeQ.pm) + 1'b1) << (modeQ.div16 ? 5 : 1);
  assign halfM1  = halfLen - 1'b1;

  assign loadS = modeQ.en && txFullQ && !busyQ;
  assign tickS = modeQ.en && busyQ && prescQ == halfM1;
  assign lastS = edgeQ == lastIdx;
  assign leadS = !edgeQ[0];
  assign nfSet = loadS || (!modeQ.en && txFullQ);

  always_comb begin
    stb.load   = loadS;
    stb.drive  = (loadS && !modeQ.cpha) ||
                 (tickS && (modeQ.cpha ? leadS : (!leadS && !lastS)));
    stb.sample = tickS && (modeQ.cpha ? !leadS : leadS);
    stb.done   = tickS && lastS;
    stb.abort  = !modeQ.en;
  end

  always_comb begin
    evtN = evtQ;
    if (wrEvtS) evtN = evtN & ~regWrData[1:0];
    if (nfSet)  evtN[EV_NF] = 1'b1;
    if (wrTxS)  evtN[EV_NF] = 1'b0;
    if (stb.done) evtN[EV_NE] = 1'b1;
  end

  always_comb begin
    case (regAddr)
      ADDR_MODE:  regRdData = modeToWord(modeQ);
      ADDR_EVENT: regRdData = {30'd0, evtQ};
      ADDR_MASK:  regRdData = {30'd0, maskQ};
      ADDR_RX:    regRdData = rxWord;
      ADDR_SEL:   regRdData = DATA_W'(selQ);
      ADDR_CAP:   regRdData = CAP_WORD;
      default:    regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0; evtQ <= 2'b01; maskQ <= '0; selQ <= '1; txQ <= '0;
      txFullQ <= 1'b0; busyQ <= 1'b0; sckQ <= 1'b0;
      edgeQ <= '0; prescQ <= '0;
    end else begin
      evtQ <= evtN;
      if (wrMaskS) maskQ <= regWrData[1:0];
      if (wrSelS)  selQ  <= regWrData[NSEL-1:0];
      if (wrModeS) begin
        if (modeQ.en) modeQ.en <= regWrData[0];
        else          modeQ    <= wordToMode(regWrData);
      end
      if (!modeQ.en) begin
        txFullQ <= 1'b0; busyQ <= 1'b0; sckQ <= modeQ.cpol;
        edgeQ <= '0; prescQ <= '0;
      end else begin
        if (loadS) begin
          txFullQ <= 1'b0; busyQ <= 1'b1; sckQ <= modeQ.cpol;
          edgeQ <= '0; prescQ <= '0;
        end else if (busyQ) begin
          prescQ <= tickS ? '0 : prescQ + 1'b1;
          if (tickS) begin
            sckQ  <= ~sckQ;
            edgeQ <= edgeQ + 1'b1;
            if (lastS) busyQ <= 1'b0;
          end
        end
        if (wrTxS) begin
          txQ <= regWrData;
          txFullQ <= 1'b1;
        end
      end
    end
  end

  assign modeCfg  = modeQ;
  assign txWord   = txQ;
  assign fullWord = modeQ.lenF == '0;
  assign sckOut   = sckQ;
  assign irqOut   = |(evtQ & maskQ);
  assign selOut   = selQ;
endmodule

// File: rtl/spi_m_top.sv
`timescale 1ns/1ps
module spi_m_top
  import spi_m_pkg::*;
#(
  parameter int NSEL = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic [NSEL-1:0]   selOut
);
  spiStrobe_t        stb;
  spiMode_t          modeCfg;
  logic [DATA_W-1:0] txWord, rxWord;
  logic              fullWord;

  spi_m_control #(.NSEL(NSEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rxWord(rxWord), .regRdData(regRdData),
    .stb(stb), .modeCfg(modeCfg), .txWord(txWord), .fullWord(fullWord),
    .sckOut(sckOut), .irqOut(irqOut), .selOut(selOut)
  );

  spi_m_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWord(txWord),
    .msbFirst(modeCfg.msbFirst), .loopBack(modeCfg.loopBack),
    .fullWord(fullWord), .misoIn(misoIn), .mosiOut(mosiOut), .rxWord(rxWord)
  );
endmodule

// File: rtl/spi_m_check.sv
`timescale 1ns/1ps
module spi_m_check
  import spi_m_pkg::*;
#(
  parameter int NSEL = 4
)(
  input logic              clk,
  input logic              rstN,
  input spiMode_t          modeCfg,
  input spiStrobe_t        stb,
  input logic              sckOut,
  input logic [NSEL-1:0]   selOut,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData
);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeCfg.en |=> $stable({modeCfg.pm, modeCfg.div16, modeCfg.lenF, modeCfg.loopBack,
                            modeCfg.msbFirst, modeCfg.cpol, modeCfg.cpha}));

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeCfg.en |=> sckOut == $past(modeCfg.cpol));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> sckOut == modeCfg.cpol);

  // R11
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeCfg.en |-> !stb.load && !stb.done && !stb.sample);

  // R9
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !stb.load);

  // R12
  sel_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_SEL |=> selOut == $past(regWrData[NSEL-1:0]));
endmodule

bind spi_m_top spi_m_check #(.NSEL(NSEL)) chkInst (
  .clk(clk), .rstN(rstN), .modeCfg(modeCfg), .stb(stb), .sckOut(sckOut),
  .selOut(selOut), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData)
);

// File: tb/spi_m_top_test.sv
`timescale 1ns/1ps
module spi_m_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic irqOut, sckOut, mosiOut;
  logic misoIn = 1'b0;
  logic [3:0] selOut;

  int checks = 0;
  int errors = 0;

  logic monOn = 1'b0;
  logic sCpol, sCpha, sMsb;
  int sLen;
  logic [31:0] sWord, capSeq;
  int capCnt, sendIdx, edgeNum, gapBad;
  longint lastT, expGap;

  spi_m_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut),
    .sckOut(sckOut), .mosiOut(mosiOut), .misoIn(misoIn), .selOut(selOut)
  );

  always #2.5 clk = ~clk;

  function automatic logic slaveBit(int i);
    if (i >= sLen) return 1'b0;
    return sMsb ? sWord[sLen-1-i] : sWord[i];
  endfunction

  // Bench slave: captures on master sample edges, drives on the others
  always @(sckOut) begin
    if (monOn) begin
      if (edgeNum > 0 && (longint'($time) - lastT) != expGap) gapBad++;
      lastT = longint'($time);
      edgeNum++;
      if ((sckOut != sCpol) ^ sCpha) begin
        capSeq = {capSeq[30:0], mosiOut};
        capCnt++;
      end else begin
        misoIn = slaveBit(sendIdx);
        sendIdx++;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitNe(output logic [31:0] v);
    for (int i = 0; i < 40000; i++) begin
      rdReg(3'd1, v);
      if (v[1]) break;
    end
  endtask

  function automatic logic [31:0] mkMode(logic en, logic cpha, logic cpol, logic msb,
                                         logic lb, int len, logic d16, int pm);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = cpha; w[2] = cpol; w[3] = msb; w[4] = lb;
    w[11:8] = (len == 32) ? 4'd0 : 4'(len - 1);
    w[12] = d16;
    w[19:16] = 4'(pm);
    return w;
  endfunction

  task automatic doXfer(input string tag, input logic cpha, input logic cpol, input logic msb,
                        input logic lb, input int len, input logic d16, input int pm,
                        input logic [31:0] tx, input logic [31:0] sw);
    logic [31:0] cfg, v, msk, eff, expRx, expSeq;
    cfg = mkMode(1'b0, cpha, cpol, msb, lb, len, d16, pm);
    msk = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    eff = sw & msk;
    if (lb) eff = (len == 32) ? tx : (msb ? (tx >> (32 - len)) : (tx & msk));
    expRx = (len == 32) ? eff : (msb ? (eff << 16) : (eff << (16 - len)));
    expSeq = '0;
    for (int i = 0; i < len; i++) expSeq = {expSeq[30:0], msb ? tx[31-i] : tx[i]};
    wrReg(3'd0, cfg);
    wrReg(3'd0, cfg | 32'h1);
    sCpol = cpol; sCpha = cpha; sMsb = msb; sLen = len; sWord = sw;
    expGap = longint'(2 * (pm + 1) * (d16 ? 16 : 1) * 5);
    capSeq = '0; capCnt = 0; edgeNum = 0; gapBad = 0;
    if (!cpha) begin misoIn = slaveBit(0); sendIdx = 1; end
    else sendIdx = 0;
    monOn = 1'b1;
    wrReg(3'd3, tx);
    waitNe(v);
    monOn = 1'b0;
    chk("R9", {tag, " word-waiting set"}, {31'd0, v[1]}, 32'd1);
    rdReg(3'd4, v);
    chk(lb ? "R8" : "R7", {tag, " received word"}, v, expRx);
    chk("R6", {tag, " mosi sequence"}, capSeq, expSeq);
    chk("R3", {tag, " bit count"}, 32'(capCnt), 32'(len));
    chk("R4", {tag, " half-period spacing"}, 32'(gapBad), 32'd0);
    chk("R5", {tag, " sck idle after word"}, {31'd0, sckOut}, {31'd0, cpol});
    wrReg(3'd1, 32'h3);
    wrReg(3'd0, cfg);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(3'd0, v); chk("R1", "mode", v, 32'h0);
    rdReg(3'd1, v); chk("R1", "event", v, 32'h1);
    rdReg(3'd2, v); chk("R1", "mask", v, 32'h0);
    chk("R1", "irq", {31'd0, irqOut}, 32'd0);
    chk("R1", "sck", {31'd0, sckOut}, 32'd0);
    chk("R12", "select reset", {28'd0, selOut}, 32'hF);
    rdReg(3'd6, v); chk("R12", "capability", v, 32'h0004011F);
  endtask

  task automatic testModeGate();
    logic [31:0] v;
    wrReg(3'd0, 32'h0003070A); rdReg(3'd0, v); chk("R2", "write while off", v, 32'h0003070A);
    wrReg(3'd0, 32'h0003070B); rdReg(3'd0, v); chk("R2", "enable", v, 32'h0003070B);
    wrReg(3'd0, 32'h000F1F15); rdReg(3'd0, v); chk("R2", "fields held while on", v, 32'h0003070B);
    wrReg(3'd0, 32'h0); rdReg(3'd0, v); chk("R2", "disable keeps fields", v, 32'h0003070A);
    wrReg(3'd0, 32'h0); rdReg(3'd0, v); chk("R2", "clear while off", v, 32'h0);
  endtask

  task automatic testEvents();
    logic [31:0] v, cfg;
    cfg = mkMode(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8, 1'b0, 3);
    wrReg(3'd2, 32'h0);
    wrReg(3'd0, cfg);
    wrReg(3'd3, 32'hA500_0000);
    peek(3'd1, v); chk("R9", "ready clears on tx write", v & 32'h1, 32'h0);
    @(negedge clk); peek(3'd1, v); chk("R9", "ready sets on load", v & 32'h1, 32'h1);
    chk("R10", "irq masked off", {31'd0, irqOut}, 32'd0);
    waitNe(v);
    chk("R10", "irq still masked", {31'd0, irqOut}, 32'd0);
    wrReg(3'd2, 32'h2); chk("R10", "irq on word-waiting", {31'd0, irqOut}, 32'd1);
    wrReg(3'd1, 32'h2); rdReg(3'd1, v);
    chk("R9", "write-one clears word-waiting", v, 32'h1);
    chk("R10", "irq after clear", {31'd0, irqOut}, 32'd0);
    wrReg(3'd2, 32'h1); chk("R10", "irq on ready", {31'd0, irqOut}, 32'd1);
    wrReg(3'd2, 32'h0);
    wrReg(3'd0, cfg & ~32'h1);
  endtask

  task automatic testAbort();
    logic [31:0] v, cfg;
    cfg = mkMode(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32, 1'b0, 15);
    wrReg(3'd0, cfg); wrReg(3'd0, cfg | 32'h1);
    wrReg(3'd3, 32'hFFFF_0000);
    repeat (100) @(negedge clk);
    wrReg(3'd0, cfg);
    @(negedge clk);
    chk("R11", "sck idle after abort", {31'd0, sckOut}, 32'd1);
    repeat (3000) @(negedge clk);
    rdReg(3'd1, v); chk("R11", "no word after abort", v, 32'h1);
    wrReg(3'd3, 32'h1234_5678);
    rdReg(3'd1, v); chk("R11", "tx write ignored while off", v, 32'h1);
    wrReg(3'd0, cfg | 32'h1);
    repeat (200) @(negedge clk);
    rdReg(3'd1, v); chk("R11", "nothing starts after re-enable", v, 32'h1);
    chk("R11", "sck quiet after re-enable", {31'd0, sckOut}, 32'd1);
    wrReg(3'd0, cfg);
  endtask

  task automatic testOverwrite();
    logic [31:0] v, cfg;
    cfg = mkMode(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8, 1'b0, 0);
    wrReg(3'd0, cfg);
    wrReg(3'd3, 32'h1100_0000);
    repeat (100) @(negedge clk);
    wrReg(3'd3, 32'h3C00_0000);
    repeat (100) @(negedge clk);
    rdReg(3'd4, v); chk("R13", "second word overwrites", v, 32'h003C_0000);
    wrReg(3'd1, 32'h3);
    wrReg(3'd0, cfg & ~32'h1);
  endtask

  task automatic testSelect();
    logic [31:0] v;
    wrReg(3'd5, 32'h5);
    chk("R12", "select drive", {28'd0, selOut}, 32'h5);
    rdReg(3'd5, v); chk("R12", "select readback", v, 32'h5);
    wrReg(3'd6, 32'hFFFF_FFFF);
    rdReg(3'd6, v); chk("R12", "capability read-only", v, 32'h0004011F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testModeGate();
    doXfer("msb8 ph0 po0", 1'b0, 1'b0, 1'b1, 1'b0, 8, 1'b0, 0, 32'hA5FF_FFFF, 32'h0000_003C);
    doXfer("lsb8 ph1 po1", 1'b1, 1'b1, 1'b0, 1'b0, 8, 1'b0, 2, 32'hFFFF_FF96, 32'h0000_00C3);
    doXfer("msb16 ph1 po0", 1'b1, 1'b0, 1'b1, 1'b0, 16, 1'b0, 1, 32'hBEEF_0000, 32'h0000_1234);
    doXfer("lsb32 ph0 po1", 1'b0, 1'b1, 1'b0, 1'b0, 32, 1'b0, 0, 32'h8BAD_F00D, 32'hC001_D00D);
    doXfer("msb4 div16", 1'b0, 1'b0, 1'b1, 1'b0, 4, 1'b1, 1, 32'h9000_0000, 32'h0000_0006);
    doXfer("lsb12 ph0 po0", 1'b0, 1'b0, 1'b0, 1'b0, 12, 1'b0, 0, 32'h0000_0ABC, 32'h0000_0F0A);
    doXfer("msb32 ph1 po1", 1'b1, 1'b1, 1'b1, 1'b0, 32, 1'b0, 0, 32'h1357_9BDF, 32'hFEDC_BA98);
    doXfer("loop msb8", 1'b0, 1'b0, 1'b1, 1'b1, 8, 1'b0, 0, 32'h5A00_0000, 32'h0000_00FF);
    doXfer("loop lsb12", 1'b1, 1'b0, 1'b0, 1'b1, 12, 1'b0, 1, 32'h0000_0E71, 32'h0000_0000);
    testEvents();
    testAbort();
    testOverwrite();
    testSelect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule